// File: doc/BRIEF.md
# Control/Status Register Bank with Mixed Field Semantics

This block is a processor-facing register bank. A simple bus presents a byte address, a write strobe with write data, and a read strobe; read data comes back registered one cycle later. Each register is assembled from fields, and each field has its own access rule. Supported rules are plain read/write, read-only, sticky clear-on-read, sticky write-one-to-clear, sticky loaded by direct write, and interrupt status with a companion enable mask. One interrupt line is formed from the enabled status bits.

A 48-bit value is spread over two word addresses. Reading the low word takes a snapshot of the upper bits, so the two halves read back coherently. A command register has a post-write action that overrides the stored value and emits a one-cycle strobe. A group of channel registers repeats at a fixed stride. Bus addresses are byte addresses. They are scaled by a configurable address multiple before decode.

Top module: `csr_bank`

## Requirements
- R1: After reset, ctrl_q is 0x00A5, every other stored field, wide_q, cmd_q, chan_cfg, chan_en, bus_rdata, irq and cmd_go are 0.
- R2: The word index is bus_addr divided by 4. A byte address that is not a multiple of 4, or that hits no register, returns 0 on read and changes nothing on write.
- R3: bus_rdata carries the addressed value in the cycle after bus_rd is sampled high and is 0 in the cycle after bus_rd is sampled low.
- R4: Address 0x00 holds a 16-bit read/write field in bits [15:0], driven on ctrl_q. Bits [31:16] read as 0.
- R5: Address 0x04 bits [15:0] reflect stat_in, and writes to it have no effect.
- R6: Address 0x08 bits [7:0] are sticky copies of evt_cor_in. A read returns the value held before the read and then clears it, but an event in the read cycle stays set.
- R7: Address 0x0C bits [7:0] are sticky copies of evt_w1c_in. A bit clears only when written with 1, and an event in the same cycle keeps it set.
- R8: Address 0x10 bits [7:0] are sticky copies of evt_st_in. A write loads the written byte, ORed with any event in that cycle.
- R9: Address 0x14 bits [7:0] are interrupt status, set by irq_src and cleared by writing 1. Address 0x18 bits [7:0] are an enable mask where 1 means enabled. irq equals the OR of status AND mask, one cycle after the status and mask registers update.
- R10: A 48-bit field is driven on wide_q. A write to 0x1C loads bits [31:0], and a write to 0x20 loads bits [47:32] from write-data bits [15:0].
- R11: A read of 0x1C snapshots wide_q[47:32]. A read of 0x20 returns that snapshot in bits [15:0], not the live upper bits.
- R12: Address 0x24 stores write-data bits [7:0] on cmd_q, except that bit 7 always stores 0. A write with bit 7 set raises cmd_go for exactly the one cycle after the write.
- R13: For channel i in 0..3, address 0x40+8i holds cfg in bits [7:0] (chan_cfg[8i+7:8i]) and an enable in bit 8 (chan_en[i]). Address 0x44+8i bit 0 reflects chan_busy[i] and is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| ctrl_q | output | 16 | Read/write control field |
| stat_in | input | 16 | Read-only status field |
| evt_cor_in | input | 8 | Clear-on-read event inputs |
| evt_w1c_in | input | 8 | Write-one-to-clear event inputs |
| evt_st_in | input | 8 | Direct-write sticky event inputs |
| irq_src | input | 8 | Interrupt event inputs |
| irq | output | 1 | Registered interrupt line |
| wide_q | output | 48 | Wide split field |
| cmd_q | output | 8 | Command field |
| cmd_go | output | 1 | One-cycle command strobe |
| chan_cfg | output | 32 | Channel cfg fields, 8 bits per channel |
| chan_en | output | 4 | Channel enable bits |
| chan_busy | input | 4 | Channel busy inputs |

## Verification
A write or event updates its register at the first rising edge that samples it. Output ports such as ctrl_q, wide_q, cmd_q and cmd_go are therefore compared at the falling edge that closes the strobe cycle. Read data is registered once, so every read is compared at the falling edge after the sampling edge. irq sits one register further on, so the bench waits one more idle cycle before comparing it against the status and mask model. Simultaneous event-and-clear cases are driven in the same strobe cycle, so that the set-wins rule is seen at the next read.

// File: rtl/csr_pkg.sv
package csr_pkg;

   // Sticky field flavours, chosen per instance by a parameter
   typedef enum logic [1:0] {
      STK_COR    = 2'd0,   // cleared when its word is read
      STK_W1C    = 2'd1,   // bit cleared by writing a one
      STK_DIRECT = 2'd2    // loaded with the written value
   } stk_mode_e;

   // Word offsets of the fixed registers (byte address / multiple)
   localparam int W_CTRL  = 0;
   localparam int W_STAT  = 1;
   localparam int W_COR   = 2;
   localparam int W_W1C   = 3;
   localparam int W_ST    = 4;
   localparam int W_ISTAT = 5;
   localparam int W_IMASK = 6;
   localparam int W_WLO   = 7;
   localparam int W_WHI   = 8;
   localparam int W_CMD   = 9;
   localparam int W_LAST  = W_CMD;

endpackage

// File: rtl/csr_sticky.sv
module csr_sticky #(
   parameter int                  W    = 8,
   parameter csr_pkg::stk_mode_e  MODE = csr_pkg::STK_W1C
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  evt,
   input  logic          wr_hit,
   input  logic          rd_hit,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  q
);

   logic [W-1:0] keep;
   logic         unused_sink;

   assign unused_sink = ^{wr_hit, rd_hit, wdata};

   generate
      if (MODE == csr_pkg::STK_COR) begin : g_cor
         assign keep = rd_hit ? '0 : q;
      end else if (MODE == csr_pkg::STK_W1C) begin : g_w1c
         assign keep = wr_hit ? (q & ~wdata) : q;
      end else begin : g_direct
         assign keep = wr_hit ? wdata : q;
      end
   endgenerate

   // event is ORed last so a set in a clear cycle is never lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= keep | evt;
   end

endmodule

// File: rtl/csr_wide_split.sv
module csr_wide_split #(
   parameter int DATA_W = 32,
   parameter int WIDE_W = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              rd_lo,
   input  logic [DATA_W-1:0] wdata,
   output logic [WIDE_W-1:0] wide_q,
   output logic [DATA_W-1:0] lo_rd,
   output logic [DATA_W-1:0] hi_rd
);

   localparam int HI_W = WIDE_W - DATA_W;

   logic [HI_W-1:0] shadow_q;

   // upper part owns the full-width storage; each address loads its slice
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wide_q <= '0;
      end else begin
         if (wr_lo) wide_q[DATA_W-1:0]      <= wdata;
         if (wr_hi) wide_q[WIDE_W-1:DATA_W] <= wdata[HI_W-1:0];
      end
   end

   // read action on the low word freezes the upper slice for a later read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     shadow_q <= '0;
      else if (rd_lo) shadow_q <= wide_q[WIDE_W-1:DATA_W];
   end

   assign lo_rd = wide_q[DATA_W-1:0];
   assign hi_rd = DATA_W'(shadow_q);

endmodule

// File: rtl/csr_rpt_group.sv
module csr_rpt_group #(
   parameter int DATA_W   = 32,
   parameter int IDX_W    = 6,
   parameter int N        = 4,
   parameter int CFG_W    = 8,
   parameter int BASE_W   = 16,
   parameter int STRIDE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [IDX_W-1:0]   idx,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [N-1:0]       busy,
   output logic [N*CFG_W-1:0] cfg,
   output logic [N-1:0]       en,
   output logic               hit,
   output logic [DATA_W-1:0]  rd_data
);

   logic [DATA_W-1:0] part [N];
   logic [N-1:0]      hitv;
   logic              unused_sink;

   assign unused_sink = ^wdata[DATA_W-1:CFG_W+1];

   generate
      for (genvar gi = 0; gi < N; gi++) begin : g_ch
         localparam logic [IDX_W-1:0] CW = IDX_W'(BASE_W + gi * STRIDE_W);
         localparam logic [IDX_W-1:0] SW = IDX_W'(BASE_W + gi * STRIDE_W + 1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cfg[gi*CFG_W +: CFG_W] <= '0;
               en[gi]                 <= 1'b0;
            end else if (wr && idx == CW) begin
               cfg[gi*CFG_W +: CFG_W] <= wdata[CFG_W-1:0];
               en[gi]                 <= wdata[CFG_W];
            end
         end

         always_comb begin
            part[gi] = '0;
            if (idx == CW)      part[gi] = DATA_W'({en[gi], cfg[gi*CFG_W +: CFG_W]});
            else if (idx == SW) part[gi] = DATA_W'(busy[gi]);
         end

         assign hitv[gi] = (idx == CW) || (idx == SW);
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < N; i++) rd_data |= part[i];
   end

   assign hit = |hitv;

endmodule

// File: rtl/csr_bank.sv
module csr_bank #(
   parameter int              ADDR_W     = 8,
   parameter int              DATA_W     = 32,
   parameter int              ADDR_MULT  = 4,
   parameter int              CTRL_W     = 16,
   parameter logic [15:0]     CTRL_RST   = 16'h00A5,
   parameter int              STAT_W     = 16,
   parameter int              EVT_W      = 8,
   parameter int              WIDE_W     = 48,
   parameter int              CMD_W      = 8,
   parameter int              RPT_N      = 4,
   parameter int              CFG_W      = 8,
   parameter int              RPT_BASE   = 'h40,
   parameter int              RPT_STRIDE = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic                   bus_wr,
   input  logic [DATA_W-1:0]      bus_wdata,
   input  logic                   bus_rd,
   output logic [DATA_W-1:0]      bus_rdata,
   output logic [CTRL_W-1:0]      ctrl_q,
   input  logic [STAT_W-1:0]      stat_in,
   input  logic [EVT_W-1:0]       evt_cor_in,
   input  logic [EVT_W-1:0]       evt_w1c_in,
   input  logic [EVT_W-1:0]       evt_st_in,
   input  logic [EVT_W-1:0]       irq_src,
   output logic                   irq,
   output logic [WIDE_W-1:0]      wide_q,
   output logic [CMD_W-1:0]       cmd_q,
   output logic                   cmd_go,
   output logic [RPT_N*CFG_W-1:0] chan_cfg,
   output logic [RPT_N-1:0]       chan_en,
   input  logic [RPT_N-1:0]       chan_busy
);
   import csr_pkg::*;

   localparam int AM_LSB       = $clog2(ADDR_MULT);
   localparam int IDX_W        = ADDR_W - AM_LSB;
   localparam int RPT_BASE_W   = RPT_BASE / ADDR_MULT;
   localparam int RPT_STRIDE_W = RPT_STRIDE / ADDR_MULT;
   localparam int GO_BIT       = CMD_W - 1;

   localparam logic [IDX_W-1:0] I_CTRL  = IDX_W'(W_CTRL);
   localparam logic [IDX_W-1:0] I_STAT  = IDX_W'(W_STAT);
   localparam logic [IDX_W-1:0] I_COR   = IDX_W'(W_COR);
   localparam logic [IDX_W-1:0] I_W1C   = IDX_W'(W_W1C);
   localparam logic [IDX_W-1:0] I_ST    = IDX_W'(W_ST);
   localparam logic [IDX_W-1:0] I_ISTAT = IDX_W'(W_ISTAT);
   localparam logic [IDX_W-1:0] I_IMASK = IDX_W'(W_IMASK);
   localparam logic [IDX_W-1:0] I_WLO   = IDX_W'(W_WLO);
   localparam logic [IDX_W-1:0] I_WHI   = IDX_W'(W_WHI);
   localparam logic [IDX_W-1:0] I_CMD   = IDX_W'(W_CMD);

   // elaboration-time parameter checks
   initial begin
      assert ((1 << AM_LSB) == ADDR_MULT) else $error("ADDR_MULT must be a power of two");
      assert (RPT_BASE % ADDR_MULT == 0 && RPT_STRIDE % ADDR_MULT == 0)
         else $error("repeat base and stride must be multiples of ADDR_MULT");
      assert (RPT_STRIDE_W >= 2) else $error("repeat stride must cover two words");
      assert (RPT_BASE_W > W_LAST) else $error("repeat group overlaps fixed registers");
      assert (RPT_BASE_W + RPT_N * RPT_STRIDE_W <= (1 << IDX_W)) else $error("repeat group exceeds address space");
      assert (WIDE_W > DATA_W && WIDE_W <= 2 * DATA_W) else $error("wide field must span exactly two words");
      assert (CTRL_W <= 16 && STAT_W <= DATA_W && EVT_W <= DATA_W && CMD_W <= DATA_W)
         else $error("field wider than its word");
      assert (CFG_W + 1 <= DATA_W) else $error("channel word too narrow");
   end

   // ---------------- address decode ----------------
   logic             aligned;
   logic [IDX_W-1:0] idx;
   logic             wr_ok, rd_ok;

   assign aligned = (int'(bus_addr) % ADDR_MULT) == 0;
   assign idx     = IDX_W'(bus_addr >> AM_LSB);
   assign wr_ok   = bus_wr & aligned;
   assign rd_ok   = bus_rd & aligned;

   // ---------------- plain read/write fields ----------------
   logic [EVT_W-1:0] imask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= CTRL_RST[CTRL_W-1:0];
         imask_q <= '0;
      end else begin
         if (wr_ok && idx == I_CTRL)  ctrl_q  <= bus_wdata[CTRL_W-1:0];
         if (wr_ok && idx == I_IMASK) imask_q <= bus_wdata[EVT_W-1:0];
      end
   end

   // ---------------- command register with post-write action ----------------
   logic             wr_cmd;
   logic [CMD_W-1:0] cmd_nxt;

   assign wr_cmd = wr_ok && idx == I_CMD;

   always_comb begin
      cmd_nxt = cmd_q;
      if (wr_cmd) cmd_nxt = bus_wdata[CMD_W-1:0];
      // action runs after the basic store and overrides it
      if (wr_cmd && bus_wdata[GO_BIT]) cmd_nxt[GO_BIT] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         cmd_go <= 1'b0;
      end else begin
         cmd_q  <= cmd_nxt;
         cmd_go <= wr_cmd && bus_wdata[GO_BIT];
      end
   end

   // ---------------- sticky fields ----------------
   logic [EVT_W-1:0] cor_q, w1c_q, st_q, istat_q;

   csr_sticky #(.W(EVT_W), .MODE(STK_COR)) u_cor (
      .clk(clk), .rst_n(rst_n), .evt(evt_cor_in),
      .wr_hit(1'b0), .rd_hit(rd_ok && idx == I_COR),
      .wdata(bus_wdata[EVT_W-1:0]), .q(cor_q));

   csr_sticky #(.W(EVT_W), .MODE(STK_W1C)) u_w1c (
      .clk(clk), .rst_n(rst_n), .evt(evt_w1c_in),
      .wr_hit(wr_ok && idx == I_W1C), .rd_hit(1'b0),
      .wdata(bus_wdata[EVT_W-1:0]), .q(w1c_q));

   csr_sticky #(.W(EVT_W), .MODE(STK_DIRECT)) u_st (
      .clk(clk), .rst_n(rst_n), .evt(evt_st_in),
      .wr_hit(wr_ok && idx == I_ST), .rd_hit(1'b0),
      .wdata(bus_wdata[EVT_W-1:0]), .q(st_q));

   csr_sticky #(.W(EVT_W), .MODE(STK_W1C)) u_istat (
      .clk(clk), .rst_n(rst_n), .evt(irq_src),
      .wr_hit(wr_ok && idx == I_ISTAT), .rd_hit(1'b0),
      .wdata(bus_wdata[EVT_W-1:0]), .q(istat_q));

   // ---------------- wide split field ----------------
   logic [DATA_W-1:0] wlo_rd, whi_rd;

   csr_wide_split #(.DATA_W(DATA_W), .WIDE_W(WIDE_W)) u_wide (
      .clk(clk), .rst_n(rst_n),
      .wr_lo(wr_ok && idx == I_WLO), .wr_hi(wr_ok && idx == I_WHI),
      .rd_lo(rd_ok && idx == I_WLO), .wdata(bus_wdata),
      .wide_q(wide_q), .lo_rd(wlo_rd), .hi_rd(whi_rd));

   // ---------------- repeated channel group ----------------
   logic              grp_hit;
   logic [DATA_W-1:0] grp_rd;

   csr_rpt_group #(
      .DATA_W(DATA_W), .IDX_W(IDX_W), .N(RPT_N), .CFG_W(CFG_W),
      .BASE_W(RPT_BASE_W), .STRIDE_W(RPT_STRIDE_W)
   ) u_grp (
      .clk(clk), .rst_n(rst_n), .wr(wr_ok), .idx(idx), .wdata(bus_wdata),
      .busy(chan_busy), .cfg(chan_cfg), .en(chan_en),
      .hit(grp_hit), .rd_data(grp_rd));

   // ---------------- read mux and registered outputs ----------------
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      case (idx)
         I_CTRL:  rd_mux = DATA_W'(ctrl_q);
         I_STAT:  rd_mux = DATA_W'(stat_in);
         I_COR:   rd_mux = DATA_W'(cor_q);
         I_W1C:   rd_mux = DATA_W'(w1c_q);
         I_ST:    rd_mux = DATA_W'(st_q);
         I_ISTAT: rd_mux = DATA_W'(istat_q);
         I_IMASK: rd_mux = DATA_W'(imask_q);
         I_WLO:   rd_mux = wlo_rd;
         I_WHI:   rd_mux = whi_rd;
         I_CMD:   rd_mux = DATA_W'(cmd_q);
         default: rd_mux = grp_hit ? grp_rd : '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         irq       <= 1'b0;
      end else begin
         bus_rdata <= rd_ok ? rd_mux : '0;
         irq       <= |(istat_q & imask_q);
      end
   end

endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int ADDR_MULT = 4,
   parameter int CTRL_W    = 16,
   parameter int EVT_W     = 8,
   parameter int CMD_W     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq,
   input logic [CTRL_W-1:0] ctrl_q,
   input logic              cmd_go,
   input logic [EVT_W-1:0]  evt_cor_in,
   input logic [EVT_W-1:0]  cor_q,
   input logic [EVT_W-1:0]  w1c_q,
   input logic [EVT_W-1:0]  istat_q,
   input logic [EVT_W-1:0]  imask_q
);

   localparam logic [ADDR_W-1:0] BA_CTRL = ADDR_W'(csr_pkg::W_CTRL * ADDR_MULT);
   localparam logic [ADDR_W-1:0] BA_W1C  = ADDR_W'(csr_pkg::W_W1C * ADDR_MULT);
   localparam logic [ADDR_W-1:0] BA_CMD  = ADDR_W'(csr_pkg::W_CMD * ADDR_MULT);

   AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == '0); // R3

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == BA_CTRL) |=> $stable(ctrl_q)); // R4

   AST_COR_NO_LOST_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_cor_in) |=> ((cor_q & $past(evt_cor_in)) == $past(evt_cor_in))); // R6

   AST_W1C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == BA_W1C) |=> ((w1c_q & $past(w1c_q)) == $past(w1c_q))); // R7

   AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq == $past(|(istat_q & imask_q))); // R9

   AST_GO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go |-> $past(bus_wr && bus_addr == BA_CMD && bus_wdata[CMD_W-1])); // R12

endmodule

bind csr_bank csr_bank_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_MULT(ADDR_MULT),
   .CTRL_W(CTRL_W), .EVT_W(EVT_W), .CMD_W(CMD_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
   .irq(irq), .ctrl_q(ctrl_q), .cmd_go(cmd_go), .evt_cor_in(evt_cor_in),
   .cor_q(cor_q), .w1c_q(w1c_q), .istat_q(istat_q), .imask_q(imask_q)
);

// File: tb/tb_csr_bank.sv
module tb_csr_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [15:0] ctrl_q;
   logic [15:0] stat_in = '0;
   logic [7:0]  evt_cor_in = '0, evt_w1c_in = '0, evt_st_in = '0, irq_src = '0;
   logic        irq;
   logic [47:0] wide_q;
   logic [7:0]  cmd_q;
   logic        cmd_go;
   logic [31:0] chan_cfg;
   logic [3:0]  chan_en;
   logic [3:0]  chan_busy = '0;

   csr_bank dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .ctrl_q(ctrl_q), .stat_in(stat_in), .evt_cor_in(evt_cor_in),
      .evt_w1c_in(evt_w1c_in), .evt_st_in(evt_st_in), .irq_src(irq_src),
      .irq(irq), .wide_q(wide_q), .cmd_q(cmd_q), .cmd_go(cmd_go),
      .chan_cfg(chan_cfg), .chan_en(chan_en), .chan_busy(chan_busy));

   always #10 clk = ~clk;   // 50 MHz

   int n_vec = 0;
   int n_err = 0;

   // ---------------- reference model ----------------
   logic [15:0] m_ctrl;
   logic [7:0]  m_cor, m_w1c, m_st, m_ist, m_imask, m_cmd;
   logic [47:0] m_wide;
   logic [15:0] m_shadow;
   logic [7:0]  m_cfg [4];
   logic [3:0]  m_en;

   task automatic model_reset();
      m_ctrl = 16'h00A5; m_cor = 0; m_w1c = 0; m_st = 0; m_ist = 0;
      m_imask = 0; m_cmd = 0; m_wide = 0; m_shadow = 0; m_en = 0;
      for (int i = 0; i < 4; i++) m_cfg[i] = 0;
   endtask

   function automatic logic [31:0] model_read(logic [7:0] a);
      logic [31:0] v;
      v = 0;
      if (a[1:0] != 2'b00) return 0;
      case (a)
         8'h00: v = {16'h0, m_ctrl};
         8'h04: v = {16'h0, stat_in};
         8'h08: begin v = {24'h0, m_cor}; m_cor = 0; end
         8'h0C: v = {24'h0, m_w1c};
         8'h10: v = {24'h0, m_st};
         8'h14: v = {24'h0, m_ist};
         8'h18: v = {24'h0, m_imask};
         8'h1C: begin v = m_wide[31:0]; m_shadow = m_wide[47:32]; end
         8'h20: v = {16'h0, m_shadow};
         8'h24: v = {24'h0, m_cmd};
         default: begin
            if (a >= 8'h40 && a < 8'h60) begin
               int i;
               i = int'(a - 8'h40) / 8;
               if (a[2] == 1'b0) v = {23'h0, m_en[i], m_cfg[i]};
               else              v = {31'h0, chan_busy[i]};
            end
         end
      endcase
      return v;
   endfunction

   task automatic model_write(logic [7:0] a, logic [31:0] d);
      if (a[1:0] != 2'b00) return;
      case (a)
         8'h00: m_ctrl = d[15:0];
         8'h0C: m_w1c = m_w1c & ~d[7:0];
         8'h10: m_st = d[7:0];
         8'h14: m_ist = m_ist & ~d[7:0];
         8'h18: m_imask = d[7:0];
         8'h1C: m_wide[31:0] = d;
         8'h20: m_wide[47:32] = d[15:0];
         8'h24: begin m_cmd = d[7:0]; m_cmd[7] = 1'b0; end
         default: begin
            if (a >= 8'h40 && a < 8'h60 && a[2] == 1'b0) begin
               int i;
               i = int'(a - 8'h40) / 8;
               m_cfg[i] = d[7:0];
               m_en[i]  = d[8];
            end
         end
      endcase
   endtask

   // ---------------- check helpers ----------------
   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_outputs(string tag);
      logic [31:0] ecfg;
      for (int i = 0; i < 4; i++) ecfg[i*8 +: 8] = m_cfg[i];
      check({tag, " ctrl_q"}, 64'(ctrl_q), 64'(m_ctrl));
      check({tag, " wide_q"}, 64'(wide_q), 64'(m_wide));
      check({tag, " cmd_q"},  64'(cmd_q),  64'(m_cmd));
      check({tag, " chan_cfg"}, 64'(chan_cfg), 64'(ecfg));
      check({tag, " chan_en"},  64'(chan_en),  64'(m_en));
   endtask

   // ---------------- bus tasks (drive and sample on falling edges) ----------------
   task automatic do_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      model_write(a, d);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic do_read(logic [7:0] a, string tag);
      logic [31:0] e;
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      e = model_read(a);
      @(negedge clk);
      bus_rd = 1'b0;
      check(tag, 64'(bus_rdata), 64'(e));
   endtask

   task automatic pulse(logic [7:0] c, logic [7:0] w, logic [7:0] s, logic [7:0] q);
      @(negedge clk);
      evt_cor_in = c; evt_w1c_in = w; evt_st_in = s; irq_src = q;
      m_cor |= c; m_w1c |= w; m_st |= s; m_ist |= q;
      @(negedge clk);
      evt_cor_in = 0; evt_w1c_in = 0; evt_st_in = 0; irq_src = 0;
   endtask

   task automatic check_irq(string tag);
      @(negedge clk);
      check(tag, 64'(irq), 64'(|(m_ist & m_imask)));
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      void'($urandom(32'h5EED_C5A1));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 ctrl_q reset", 64'(ctrl_q), 64'h00A5);
      check("R1 irq reset", 64'(irq), 0);
      check("R1 rdata reset", 64'(bus_rdata), 0);
      check("R1 cmd_go reset", 64'(cmd_go), 0);
      check_outputs("R1");
      do_read(8'h08, "R1 cor reset");
      do_read(8'h14, "R1 istat reset");

      // R4 read/write field, upper bits read zero
      do_write(8'h00, 32'hFFFF_1234);
      check_outputs("R4");
      do_read(8'h00, "R4 ctrl readback");

      // R3 idle cycle after read gives zero
      @(negedge clk);
      check("R3 rdata idle", 64'(bus_rdata), 0);

      // R5 read-only
      stat_in = 16'hBEEF;
      do_read(8'h04, "R5 stat");
      do_write(8'h04, 32'h0000_1111);
      do_read(8'h04, "R5 stat after write");

      // R2 misaligned and unmapped
      do_write(8'h01, 32'h0000_7777);
      check_outputs("R2 misaligned write");
      do_read(8'h02, "R2 misaligned read");
      do_write(8'h30, 32'hFFFF_FFFF);
      check_outputs("R2 unmapped write");
      do_read(8'h30, "R2 unmapped read");

      // R6 clear-on-read, set wins
      pulse(8'h05, 0, 0, 0);
      do_read(8'h08, "R6 cor first read");
      do_read(8'h08, "R6 cor cleared");
      pulse(8'h02, 0, 0, 0);
      @(negedge clk);
      bus_addr = 8'h08; bus_rd = 1'b1; evt_cor_in = 8'h80;
      begin
         logic [31:0] e;
         e = model_read(8'h08);
         m_cor |= 8'h80;
         @(negedge clk);
         bus_rd = 1'b0; evt_cor_in = 0;
         check("R6 cor read with event", 64'(bus_rdata), 64'(e));
      end
      do_read(8'h08, "R6 cor event survived");

      // R7 write-one-to-clear
      pulse(0, 8'hF0, 0, 0);
      do_write(8'h0C, 32'h30);
      do_read(8'h0C, "R7 w1c partial clear");
      do_write(8'h0C, 32'h0);
      do_read(8'h0C, "R7 w1c zero keeps");
      @(negedge clk);
      bus_addr = 8'h0C; bus_wdata = 32'h40; bus_wr = 1'b1; evt_w1c_in = 8'h40;
      model_write(8'h0C, 32'h40); m_w1c |= 8'h40;
      @(negedge clk);
      bus_wr = 1'b0; evt_w1c_in = 0;
      do_read(8'h0C, "R7 w1c set wins");

      // R8 direct-write sticky
      pulse(0, 0, 8'h11, 0);
      do_read(8'h10, "R8 st captured");
      do_write(8'h10, 32'h0);
      do_read(8'h10, "R8 st cleared by write");
      pulse(0, 0, 8'h03, 0);
      do_write(8'h10, 32'h80);
      do_read(8'h10, "R8 st loaded");

      // R9 interrupt status and mask
      pulse(0, 0, 0, 8'h04);
      check_irq("R9 masked irq");
      do_write(8'h18, 32'h04);
      check_irq("R9 enabled irq");
      do_write(8'h14, 32'h04);
      check_irq("R9 irq after clear");

      // R10 wide field slices
      do_write(8'h1C, 32'hDEAD_BEEF);
      do_write(8'h20, 32'hFFFF_1234);
      check_outputs("R10");

      // R11 snapshot on low read
      do_read(8'h1C, "R11 low read");
      do_write(8'h20, 32'h5555);
      do_read(8'h20, "R11 high returns snapshot");
      do_read(8'h1C, "R11 low read again");
      do_read(8'h20, "R11 high after new snapshot");

      // R12 command action
      do_write(8'h24, 32'h85);
      check("R12 go pulse", 64'(cmd_go), 1);
      @(negedge clk);
      check("R12 go one cycle", 64'(cmd_go), 0);
      do_read(8'h24, "R12 cmd readback");
      do_write(8'h24, 32'h03);
      check("R12 no go", 64'(cmd_go), 0);
      check_outputs("R12");

      // R13 channel group
      chan_busy = 4'b1010;
      do_write(8'h48, 32'h1AB);
      do_write(8'h58, 32'h0CD);
      check_outputs("R13");
      do_read(8'h48, "R13 ch1 cfg");
      do_read(8'h4C, "R13 ch1 busy");
      do_read(8'h54, "R13 ch2 busy");

      // constrained random mix
      for (int n = 0; n < 400; n++) begin
         int op;
         logic [7:0]  a;
         logic [31:0] d;
         op = int'($urandom_range(0, 2));
         a  = 8'($urandom_range(0, 95));
         d  = $urandom;
         stat_in   = 16'($urandom);
         chan_busy = 4'($urandom);
         if (op == 0) begin
            do_write(a, d);
            check("R12 go after random write", 64'(cmd_go), 64'(a == 8'h24 && d[7]));
            check_outputs("R2 random write");
         end else if (op == 1) begin
            do_read(a, "R3 random read");
         end else begin
            pulse(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
         end
         check_irq("R9 random irq");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

endmodule